// File: doc/BRIEF.md
# Flash Memory Bus Read Interface

This block is the device-side front end of a parallel flash-style memory bus. Five active-low control pins are decoded into bus operations: chip select, read strobe, write strobe, output kill and address-hold strobe. Every control pin passes through its own glitch filter running on a fast internal clock. The address and data-in lines are delayed by the same number of cycles, so they stay lined up with the filtered controls. Reads return either a word from a small computed array or one of four register locations: a two-word identity code, a status word, a query table and the mode register. The three-state data bus is split into a data-out vector and a drive-enable pin.

Out of reset the interface runs plain asynchronous reads: the live address selects the word. A two-write command sequence loads the mode register from the address lines. Once the register has been loaded with its hold-mode bit set, the address is captured when the address-hold strobe rises. Later address changes then have no effect until the strobe is lowered again. Identity, status and query reads always bypass the captured address and use the live one. Reset brings the interface back to plain mode.

Top module: `fbus_read_if`

## Requirements
- R1: After reset release, `dq_oe` is 0 and `dout` is 0, and the mode register reads back its reset value 0x00FF at address 0xE0.
- R2: With address bit 7 low, a read returns the array word `{2'b00, a[6:0], ~a[6:0]} ^ 16'h3C00`. A read is chip select low, read strobe low, write strobe high and output kill high.
- R3: Chip select high, read strobe high, write strobe low or output kill low each force `dq_oe` to 0 and `dout` to 0.
- R4: A level change shorter than FILT_N (4) internal clocks on chip select or write strobe is ignored. A short write-strobe pulse writes nothing, and a short chip-select pulse does not interrupt a read.
- R5: The mode register is loaded by a write of data 0x0060 followed directly by a write of data 0x0003. The new value comes from `addr[7:0]` of the second write. Any other sequence leaves it unchanged. A write is the rise of the filtered write strobe while chip select is low.
- R6: Address-hold mode is active only when bit 3 of the mode register is 1 and the register has been loaded since reset. The reset value, although it has bit 3 set, does not select the mode.
- R7: In address-hold mode, the address seen while the address-hold strobe is low is captured when the strobe rises. This includes an address change applied in the same cycle as the rise. Address changes while the strobe is high do not change the word read.
- R8: In address-hold mode, holding the address-hold strobe low makes reads behave exactly like R2 reads on the live address.
- R9: Register space is address bit 7 high, and bits 6:5 select the location: 00 identity (0x00C2 with bit 0 low, 0x22D5 with bit 0 high), 01 status 0x0080, 10 query 0x0051 plus `a[3:0]`, 11 mode register zero-extended. Identity, status and query reads use the live address in every mode.
- R10: A reset after the mode register has been loaded restores the reset value and plain asynchronous reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset and power-down |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| od_n | input | 1 | Output kill, active low |
| le_n | input | 1 | Address-hold strobe, active low (transparent when low) |
| addr | input | AW | Word address |
| din | input | DW | Data-in half of the bus |
| dout | output | DW | Data-out half of the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The capture edge of the address-hold strobe and a change of the address lines can fall in the same clock. The bench provokes this by raising the strobe and moving the address in one step. It then judges the result by reading with the expected word computed for the old address, and by moving the address again while the strobe stays high. A second overlap is an identity, status or query address on the live lines while a captured array address is held. The bench expects the register word, not the held array word.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic [0:0] {CMD_IDLE, CMD_ARMED} cmd_state_t;

  localparam int NCTL  = 5;
  localparam int CI_CE = 0;
  localparam int CI_OE = 1;
  localparam int CI_WE = 2;
  localparam int CI_OD = 3;
  localparam int CI_LE = 4;

  localparam logic [1:0] REG_SIG  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_QRY  = 2'd2;
  localparam logic [1:0] REG_CFG  = 2'd3;
endpackage

// File: rtl/fbus_filter.sv
module fbus_filter #(
  parameter int   N       = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= RST_LVL;
      cnt  <= '0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == CW'(N - 1)) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the filtered level only moves to a level the raw pin really had
  p_filter_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(raw) == filt));
endmodule

// File: rtl/fbus_delay.sv
module fbus_delay #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/fbus_addr_latch.sv
module fbus_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          le_n,
  input  logic          ce_n,
  input  logic          we_n,
  output logic [AW-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      lat_q <= '0;
    else if (!le_n && !ce_n && we_n)
      lat_q <= addr_in;
  end

  // R7: once the strobe has stayed high, the captured address does not move
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && $past(le_n)) |-> $stable(lat_q));
endmodule

// File: rtl/fbus_cmd.sv
module fbus_cmd
  import fbus_pkg::*;
#(
  parameter int            AW      = 8,
  parameter int            DW      = 16,
  parameter logic [AW-1:0] CFG_RST = 8'hFF,
  parameter logic [DW-1:0] CMD_ARM = 16'h0060,
  parameter logic [DW-1:0] CMD_SET = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cfg,
  output logic          cfg_written
);
  cmd_state_t state;
  logic       we_q;
  logic       wr_pulse;

  assign wr_pulse = we_n && !we_q && !ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q        <= 1'b1;
      state       <= CMD_IDLE;
      cfg         <= CFG_RST;
      cfg_written <= 1'b0;
    end else begin
      we_q <= we_n;
      if (wr_pulse) begin
        case (state)
          CMD_IDLE: if (din == CMD_ARM) state <= CMD_ARMED;
          default: begin
            state <= CMD_IDLE;
            if (din == CMD_SET) begin
              cfg         <= addr;
              cfg_written <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R5: the register only changes as the second word of the sequence
  p_cfg_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> ($past(state) == CMD_ARMED));

  // R6: the loaded flag is only cleared by reset
  p_written_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg_written));
endmodule

// File: rtl/fbus_read_if.sv
module fbus_read_if
  import fbus_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 16,
  parameter int            FILT_N      = 4,
  parameter int            LATCH_BIT   = 3,
  parameter logic [AW-1:0] CFG_RST     = 8'hFF,
  parameter logic [DW-1:0] SIG_MFR     = 16'h00C2,
  parameter logic [DW-1:0] SIG_DEV     = 16'h22D5,
  parameter logic [DW-1:0] STATUS_WORD = 16'h0080,
  parameter logic [DW-1:0] QRY_BASE    = 16'h0051,
  parameter logic [DW-1:0] ARR_SEED    = 16'h3C00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          od_n,
  input  logic          le_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_oe
);
  localparam int IW = AW - 1;
  localparam int PW = AW + DW;

  logic [NCTL-1:0] ctl_raw, ctl_f;
  logic [AW-1:0]   addr_d, lat_q, cfg, eff;
  logic [DW-1:0]   din_d, word;
  logic            cfg_written, latch_mode, reg_forced, rd_ok;

  assign ctl_raw = {le_n, od_n, we_n, oe_n, ce_n};

  for (genvar c = 0; c < NCTL; c++) begin : g_filt
    fbus_filter #(.N(FILT_N), .RST_LVL(1'b1)) u_filt (
      .clk (clk),
      .rst_n (rst_n),
      .raw (ctl_raw[c]),
      .filt (ctl_f[c])
    );
  end

  fbus_delay #(.W(PW), .N(FILT_N)) u_align (
    .clk (clk),
    .rst_n (rst_n),
    .d ({addr, din}),
    .q ({addr_d, din_d})
  );

  fbus_addr_latch #(.AW(AW)) u_latch (
    .clk (clk),
    .rst_n (rst_n),
    .addr_in (addr_d),
    .le_n (ctl_f[CI_LE]),
    .ce_n (ctl_f[CI_CE]),
    .we_n (ctl_f[CI_WE]),
    .lat_q (lat_q)
  );

  fbus_cmd #(.AW(AW), .DW(DW), .CFG_RST(CFG_RST)) u_cmd (
    .clk (clk),
    .rst_n (rst_n),
    .ce_n (ctl_f[CI_CE]),
    .we_n (ctl_f[CI_WE]),
    .din (din_d),
    .addr (addr_d),
    .cfg (cfg),
    .cfg_written (cfg_written)
  );

  assign latch_mode = cfg_written && cfg[LATCH_BIT];
  assign reg_forced = addr_d[AW-1] && (addr_d[AW-2 -: 2] != REG_CFG);
  assign eff = (latch_mode && ctl_f[CI_LE] && !reg_forced) ? lat_q : addr_d;

  always_comb begin
    logic [IW-1:0] idx;
    idx  = eff[IW-1:0];
    word = DW'({idx, ~idx}) ^ ARR_SEED;
    if (eff[AW-1]) begin
      case (eff[AW-2 -: 2])
        REG_SIG:  word = eff[0] ? SIG_DEV : SIG_MFR;
        REG_STAT: word = STATUS_WORD;
        REG_QRY:  word = QRY_BASE + DW'(eff[3:0]);
        default:  word = DW'(cfg);
      endcase
    end
  end

  assign rd_ok = !ctl_f[CI_CE] && !ctl_f[CI_OE] && ctl_f[CI_WE] && ctl_f[CI_OD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      dq_oe <= 1'b0;
    end else begin
      dq_oe <= rd_ok;
      dout  <= rd_ok ? word : '0;
    end
  end

  // R3: a settled deselect always leaves the bus undriven
  p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_f[CI_CE] && $past(ctl_f[CI_CE])) |-> !dq_oe);
endmodule

// File: tb/tb_fbus_read_if.sv
module tb_fbus_read_if;
  localparam int N      = 4;
  localparam int SETTLE = N + 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n, od_n, le_n;
  logic [7:0]  addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic        dq_oe;
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  cfg_exp;

  always #10 clk = ~clk;

  fbus_read_if dut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .od_n (od_n), .le_n (le_n), .addr (addr), .din (din),
    .dout (dout), .dq_oe (dq_oe)
  );

  function automatic logic [15:0] f_word(input logic [7:0] a, input logic [7:0] cv);
    if (!a[7]) return {2'b00, a[6:0], ~a[6:0]} ^ 16'h3C00;
    case (a[6:5])
      2'd0:    return a[0] ? 16'h22D5 : 16'h00C2;
      2'd1:    return 16'h0080;
      2'd2:    return 16'h0051 + {12'h000, a[3:0]};
      default: return {8'h00, cv};
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; od_n = 1; le_n = 1; din = '0;
    cyc(SETTLE);
  endtask

  task automatic plain_read(input logic [7:0] a);
    le_n = 0; addr = a; we_n = 1; od_n = 1; ce_n = 0; oe_n = 0;
    cyc(SETTLE);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    addr = a; din = d; oe_n = 1; ce_n = 0; cyc(SETTLE);
    we_n = 0; cyc(SETTLE);
    we_n = 1; cyc(SETTLE);
    ce_n = 1; din = '0; cyc(SETTLE);
  endtask

  // capture a, then move to b in the same step as the strobe rises
  task automatic held_read(input logic [7:0] a, input logic [7:0] b);
    oe_n = 1; we_n = 1; od_n = 1; le_n = 0; addr = a; ce_n = 0; cyc(SETTLE);
    le_n = 1; addr = b; cyc(SETTLE);
    oe_n = 0; cyc(SETTLE);
  endtask

  task automatic do_reset();
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; od_n = 1; le_n = 1;
    addr = '0; din = '0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    cfg_exp = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  ra;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    do_reset();

    // R1 reset state
    chk("R1 dq_oe", {15'd0, dq_oe}, 16'h0000);
    chk("R1 dout", dout, 16'h0000);
    plain_read(8'hE0);
    chk("R1 cfg reset value", dout, 16'h00FF);
    idle();

    // R2 directed array reads
    plain_read(8'h00); chk("R2 a=00", dout, f_word(8'h00, cfg_exp));
    plain_read(8'h7F); chk("R2 a=7F", dout, f_word(8'h7F, cfg_exp));
    plain_read(8'h55); chk("R2 a=55", dout, f_word(8'h55, cfg_exp));
    chk("R2 drive", {15'd0, dq_oe}, 16'h0001);

    // R9 register locations in plain mode
    plain_read(8'h80); chk("R9 sig mfr", dout, 16'h00C2);
    plain_read(8'h81); chk("R9 sig dev", dout, 16'h22D5);
    plain_read(8'hA0); chk("R9 status", dout, 16'h0080);
    plain_read(8'hC3); chk("R9 query", dout, 16'h0054);

    // R3 each disqualifying pin
    oe_n = 1; cyc(SETTLE);
    chk("R3 oe high", {15'd0, dq_oe}, 16'h0000); chk("R3 oe high dout", dout, 16'h0000);
    oe_n = 0; od_n = 0; cyc(SETTLE);
    chk("R3 od low", {15'd0, dq_oe}, 16'h0000);
    od_n = 1; we_n = 0; cyc(SETTLE);
    chk("R3 we low", {15'd0, dq_oe}, 16'h0000);
    we_n = 1; ce_n = 1; cyc(SETTLE);
    chk("R3 ce high", {15'd0, dq_oe}, 16'h0000); chk("R3 ce high dout", dout, 16'h0000);
    idle();

    // R6 reset value has bit 3 set but hold mode stays off
    held_read(8'h12, 8'h34);
    chk("R6 not held before load", dout, f_word(8'h34, cfg_exp));
    idle();

    // R4 short write-strobe pulses carry a full command pair but write nothing
    ce_n = 0; din = 16'h0060; addr = 8'h00; cyc(SETTLE);
    we_n = 0; cyc(2); we_n = 1; cyc(SETTLE);
    din = 16'h0003; we_n = 0; cyc(2); we_n = 1; cyc(SETTLE);
    ce_n = 1; din = '0; cyc(SETTLE);
    plain_read(8'hE0); chk("R4 we glitch ignored", dout, 16'h00FF);
    // R4 short chip-select pulse during a read
    plain_read(8'h11);
    ce_n = 1; cyc(2); ce_n = 0; cyc(1);
    chk("R4 ce glitch drive", {15'd0, dq_oe}, 16'h0001);
    cyc(SETTLE);
    chk("R4 ce glitch drive late", {15'd0, dq_oe}, 16'h0001);
    chk("R4 ce glitch data", dout, f_word(8'h11, cfg_exp));
    idle();

    // R5 broken sequence has no effect, full sequence loads from addr
    bus_write(8'h00, 16'h0060);
    bus_write(8'h00, 16'h0005);
    bus_write(8'h08, 16'h0003);
    plain_read(8'hE0); chk("R5 broken sequence", dout, 16'h00FF);
    idle();
    bus_write(8'h00, 16'h0060);
    bus_write(8'h08, 16'h0003);
    cfg_exp = 8'h08;
    plain_read(8'hE0); chk("R5 loaded value", dout, 16'h0008);
    idle();

    // R7 capture with same-cycle address change, then later change
    held_read(8'h12, 8'h34);
    chk("R7 held address", dout, f_word(8'h12, cfg_exp));
    addr = 8'h6A; cyc(SETTLE);
    chk("R7 later change ignored", dout, f_word(8'h12, cfg_exp));

    // R9 register reads bypass the held address in hold mode
    addr = 8'h81; cyc(SETTLE); chk("R9 held mode sig", dout, 16'h22D5);
    addr = 8'hA0; cyc(SETTLE); chk("R9 held mode status", dout, 16'h0080);
    addr = 8'hC7; cyc(SETTLE); chk("R9 held mode query", dout, 16'h0058);
    idle();

    // R8 strobe held low behaves like a plain read
    plain_read(8'h2D); chk("R8 transparent", dout, f_word(8'h2D, cfg_exp));
    addr = 8'h4E; cyc(SETTLE); chk("R8 follows live", dout, f_word(8'h4E, cfg_exp));
    addr = 8'hE0; cyc(SETTLE); chk("R9 cfg in hold mode", dout, 16'h0008);
    idle();

    // R2/R9 random reads, R3 random disqualifying combinations
    for (int i = 0; i < 40; i++) begin
      ra = 8'($urandom);
      plain_read(ra);
      chk("R2 random read", dout, f_word(ra, cfg_exp));
      if (i % 4 == 0) begin
        case ($urandom % 3)
          0:       oe_n = 1;
          1:       od_n = 0;
          default: ce_n = 1;
        endcase
        cyc(SETTLE);
        chk("R3 random quiet", {15'd0, dq_oe}, 16'h0000);
        idle();
      end
    end
    idle();

    // R10 reset returns to plain mode and reset value
    do_reset();
    plain_read(8'hE0); chk("R10 cfg after reset", dout, 16'h00FF);
    idle();
    held_read(8'h21, 8'h43);
    chk("R10 plain after reset", dout, f_word(8'h43, cfg_exp));
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule